// File: doc/BRIEF.md
# Strip Detector Readout Sequencer

This block drives the readout of one silicon strip detector module. The module's front end is a chain of analog multiplexer chips. Each chip passes its token to the next one, so all channels of the module appear one after another on a single analog line. When a first-level trigger arrives, the sequencer raises a global hold so that every sample/hold channel freezes at the same instant. It then injects a token into the first chip and issues one read clock per strip. After each read clock has had time to settle, it emits an ADC sample strobe together with the index of the strip being presented.

A readout ends in one of two ways. Normally it ends after the last strip of the last chip. It ends early when a second-level reject arrives. In both cases the sequencer drops the hold, fires a one-cycle fast-reset strobe to return the multiplexers to their start position, and reports completion with a one-cycle done pulse. A fault input from the front end is latched while strips are being read. An optional calibration mode fires a charge-injection pulse a fixed time before the hold.

With the default settings, one full readout lasts 3 + 1536 × 4 cycles. At a 100 MHz clock that is about 61.5 µs, well inside a 160 µs per-event budget.

Top module: `strip_readout_seq`

## Requirements
- R1: During and immediately after reset, hold_o, rclk_o, tk_in_o, fstrb_o, pulse_o, sample_o, done_o, busy_o and err_flag_o are all 0.
- R2: A trigger sampled in idle with cal_mode_i=0 raises hold_o on the next cycle. The first rclk_o high comes HOLD_SETUP cycles later (3 by default). rclk_o is never high while hold_o is low.
- R3: tk_in_o is high for exactly the first read clock period (strip 0) and low for every later strip.
- R4: The read clock has a period of RCLK_DIV cycles (4 by default) and is high for the first RCLK_DIV/2 of them. Each period presents one strip, and a full readout covers N_CHIPS × CH_PER_CHIP = 1536 strips.
- R5: sample_o is a one-cycle pulse SETTLE cycles (2 by default) after each read clock rise. strip_idx_o carries 0, 1, … 1535 in ascending order with those pulses.
- R6: After the last strip's period ends, the next cycle shows fstrb_o=1 and hold_o=0, and the cycle after that shows done_o=1. The sequencer is then idle. fstrb_o appears HOLD_SETUP + 1536 × RCLK_DIV cycles after the trigger edge (6147 by default).
- R7: A reject sampled while a readout is active (calibration wait, hold setup or strip reading) produces fstrb_o=1 with hold_o=0 on the next cycle, then done_o. No further sample strobes follow.
- R8: busy_o is high from the cycle after an accepted trigger until the sequencer is idle again. A trigger that arrives while busy_o is high has no effect on the sample sequence or on the readout length.
- R9: fault_i sampled high while strips are being read sets err_flag_o. The flag stays set after the readout ends and is cleared by the next accepted trigger. fault_i has no effect while idle.
- R10: With cal_mode_i=1, an accepted trigger gives pulse_o=1 for one cycle on the next cycle, with hold_o still 0. hold_o rises PULSE_LEAD cycles (5 by default) after pulse_o rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_trig_i | input | 1 | First-level trigger, sampled each cycle |
| l2_rej_i | input | 1 | Second-level reject, aborts an active readout |
| fault_i | input | 1 | Token or supply fault from the front end |
| cal_mode_i | input | 1 | Selects calibration mode with charge injection |
| hold_o | output | 1 | Global sample/hold freeze to the front end |
| rclk_o | output | 1 | Read clock advancing the multiplexer chain |
| tk_in_o | output | 1 | Token injected into the first chip |
| fstrb_o | output | 1 | Fast reset of the output multiplexers |
| pulse_o | output | 1 | Charge-injection pulse in calibration mode |
| sample_o | output | 1 | ADC sample strobe |
| strip_idx_o | output | 11 | Index of the strip being sampled |
| done_o | output | 1 | One-cycle readout completion |
| busy_o | output | 1 | Readout in progress |
| err_flag_o | output | 1 | Fault seen during the last readout |

## Verification
An error in the strip phase or index counters shows up at the very next sample strobe. The index would be out of order, or the token would be present on the wrong strip, and the scoreboard reports the first such strobe. An error in the control state has two visible symptoms. One is a readout whose fast-reset strobe arrives on a cycle other than the computed one, which the bench measures exactly at the end of each readout. The other is a strobe that appears after an abort, or a hold that rises early in calibration mode; both are visible within a cycle of the wrong step.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAL   = 3'd1,
        ST_SETUP = 3'd2,
        ST_READ  = 3'd3,
        ST_ABORT = 3'd4,
        ST_DONE  = 3'd5
    } srs_state_e;

    typedef struct packed {
        logic pulse;
        logic hold;
        logic tk_in;
        logic rclk;
        logic fstrb;
    } fe_ctrl_t;

    function automatic logic is_active(srs_state_e s);
        return (s == ST_CAL) || (s == ST_SETUP) || (s == ST_READ);
    endfunction

    function automatic logic holds_frozen(srs_state_e s);
        return (s == ST_SETUP) || (s == ST_READ);
    endfunction

endpackage

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
#(
    parameter int HOLD_SETUP = 3,
    parameter int PULSE_LEAD = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  logic       rej_i,
    input  logic       cal_i,
    input  logic       scan_end_i,
    output srs_state_e state_o,
    output logic       start_o,
    output logic       pulse_o
);
    localparam int WAIT_MAX = (HOLD_SETUP > PULSE_LEAD) ? HOLD_SETUP : PULSE_LEAD;
    localparam int CW       = $clog2(WAIT_MAX + 1);

    srs_state_e     st, st_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    assign start_o = (st == ST_IDLE) && trig_i;
    assign pulse_o = (st == ST_CAL) && (cnt == '0);
    assign state_o = st;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE: begin
                cnt_nx = '0;
                if (trig_i) st_nx = cal_i ? ST_CAL : ST_SETUP;
            end
            ST_CAL: begin
                if (rej_i) st_nx = ST_ABORT;
                else if (cnt == CW'(PULSE_LEAD - 1)) begin
                    st_nx  = ST_SETUP;
                    cnt_nx = '0;
                end else cnt_nx = cnt + 1'b1;
            end
            ST_SETUP: begin
                if (rej_i) st_nx = ST_ABORT;
                else if (cnt == CW'(HOLD_SETUP - 1)) begin
                    st_nx  = ST_READ;
                    cnt_nx = '0;
                end else cnt_nx = cnt + 1'b1;
            end
            ST_READ: begin
                if (rej_i || scan_end_i) st_nx = ST_ABORT;
            end
            ST_ABORT: st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // R7
    rej_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (rej_i && is_active(st)) |=> (st == ST_ABORT));

    // R6
    abort_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ABORT) |=> (st == ST_DONE));

endmodule

// File: rtl/srs_strip_scan.sv
module srs_strip_scan #(
    parameter int N_CHIPS     = 12,
    parameter int CH_PER_CHIP = 128,
    parameter int RCLK_DIV    = 4,
    parameter int SETTLE      = 2,
    parameter int IDX_W       = $clog2(N_CHIPS * CH_PER_CHIP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             run_i,
    output logic             rclk_o,
    output logic             tk_o,
    output logic             sample_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             end_o
);
    localparam int STRIPS = N_CHIPS * CH_PER_CHIP;
    localparam int PW     = (RCLK_DIV > 2) ? $clog2(RCLK_DIV) : 1;
    localparam int HIGH   = RCLK_DIV / 2;

    logic [PW-1:0]    ph;
    logic [IDX_W-1:0] idx;
    logic             ph_wrap, last_strip;

    generate
        if ((RCLK_DIV & (RCLK_DIV - 1)) == 0) begin : g_pow2
            assign ph_wrap = &ph;
        end else begin : g_any
            assign ph_wrap = (ph == PW'(RCLK_DIV - 1));
        end
    endgenerate

    assign last_strip = (idx == IDX_W'(STRIPS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ph  <= '0;
            idx <= '0;
        end else if (run_i) begin
            if (ph_wrap) begin
                ph <= '0;
                if (!last_strip) idx <= idx + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign rclk_o   = run_i && (ph < PW'(HIGH));
    assign tk_o     = run_i && (idx == '0);
    assign sample_o = run_i && (ph == PW'(SETTLE));
    assign idx_o    = idx;
    assign end_o    = run_i && ph_wrap && last_strip;

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (rst || clear_i)
        (run_i && ph_wrap && !last_strip) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/srs_fault_latch.sv
module srs_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic watch_i,
    input  logic fault_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) flag_o <= 1'b0;
        else if (watch_i && fault_i) flag_o <= 1'b1;
    end

    // R9
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !flag_o);

endmodule

// File: rtl/strip_readout_seq.sv
module strip_readout_seq
    import srs_pkg::*;
#(
    parameter int N_CHIPS     = 12,
    parameter int CH_PER_CHIP = 128,
    parameter int RCLK_DIV    = 4,
    parameter int SETTLE      = 2,
    parameter int HOLD_SETUP  = 3,
    parameter int PULSE_LEAD  = 5,
    localparam int IDX_W      = $clog2(N_CHIPS * CH_PER_CHIP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l1_trig_i,
    input  logic             l2_rej_i,
    input  logic             fault_i,
    input  logic             cal_mode_i,
    output logic             hold_o,
    output logic             rclk_o,
    output logic             tk_in_o,
    output logic             fstrb_o,
    output logic             pulse_o,
    output logic             sample_o,
    output logic [IDX_W-1:0] strip_idx_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             err_flag_o
);
    srs_state_e st;
    logic       start, cal_pulse, scan_end, scan_rclk, scan_tk, scan_sample;
    logic       reading;
    fe_ctrl_t   fe;

    srs_fsm #(
        .HOLD_SETUP (HOLD_SETUP),
        .PULSE_LEAD (PULSE_LEAD)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (l1_trig_i),
        .rej_i      (l2_rej_i),
        .cal_i      (cal_mode_i),
        .scan_end_i (scan_end),
        .state_o    (st),
        .start_o    (start),
        .pulse_o    (cal_pulse)
    );

    assign reading = (st == ST_READ);

    srs_strip_scan #(
        .N_CHIPS     (N_CHIPS),
        .CH_PER_CHIP (CH_PER_CHIP),
        .RCLK_DIV    (RCLK_DIV),
        .SETTLE      (SETTLE),
        .IDX_W       (IDX_W)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (start),
        .run_i    (reading),
        .rclk_o   (scan_rclk),
        .tk_o     (scan_tk),
        .sample_o (scan_sample),
        .idx_o    (strip_idx_o),
        .end_o    (scan_end)
    );

    srs_fault_latch u_fault (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start),
        .watch_i (reading),
        .fault_i (fault_i),
        .flag_o  (err_flag_o)
    );

    always_comb begin
        fe.pulse = cal_pulse;
        fe.hold  = holds_frozen(st);
        fe.tk_in = scan_tk;
        fe.rclk  = scan_rclk;
        fe.fstrb = (st == ST_ABORT);
    end

    assign hold_o   = fe.hold;
    assign rclk_o   = fe.rclk;
    assign tk_in_o  = fe.tk_in;
    assign fstrb_o  = fe.fstrb;
    assign pulse_o  = fe.pulse;
    assign sample_o = scan_sample;
    assign done_o   = (st == ST_DONE);
    assign busy_o   = (st != ST_IDLE);

    // R2
    rclk_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rclk_o |-> hold_o);

    // R3
    token_on_rclk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tk_in_o) |-> $rose(rclk_o));

    // R6
    fstrb_done_chk: assert property (@(posedge clk) disable iff (rst)
        fstrb_o |=> (done_o && !hold_o && !fstrb_o));

    // R5
    sample_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o);

    // R10
    pulse_before_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (!pulse_o && !hold_o));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag_o) |-> $past(fault_i));

endmodule

// File: tb/tb_strip_readout_seq.sv
module tb_strip_readout_seq;
    localparam int STRIPS = 1536;
    localparam int STEP   = 4;
    localparam int SETUP  = 3;
    localparam int LEAD   = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l1_trig_i = 1'b0, l2_rej_i = 1'b0, fault_i = 1'b0, cal_mode_i = 1'b0;
    logic        hold_o, rclk_o, tk_in_o, fstrb_o, pulse_o, sample_o, done_o, busy_o, err_flag_o;
    logic [10:0] strip_idx_o;

    int checks = 0, errors = 0;
    bit finished = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    strip_readout_seq dut (
        .clk(clk), .rst(rst), .l1_trig_i(l1_trig_i), .l2_rej_i(l2_rej_i),
        .fault_i(fault_i), .cal_mode_i(cal_mode_i), .hold_o(hold_o), .rclk_o(rclk_o),
        .tk_in_o(tk_in_o), .fstrb_o(fstrb_o), .pulse_o(pulse_o), .sample_o(sample_o),
        .strip_idx_o(strip_idx_o), .done_o(done_o), .busy_o(busy_o), .err_flag_o(err_flag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        int e;
        if (!rst && sample_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected sample strobe", strip_idx_o, -1);
            end else begin
                e = exp_q.pop_front();
                chk(strip_idx_o == e, "R5 strip index", strip_idx_o, e);
                chk(tk_in_o == (e == 0), "R3 token only on strip 0", tk_in_o, (e == 0));
                chk(hold_o && !rclk_o, "R2 hold high at sample", hold_o, 1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    task automatic push_strips(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(i);
    endtask

    // drives a one-cycle trigger; returns at the negedge just after the accepting edge
    task automatic fire_trig();
        l1_trig_i = 1'b1;
        @(negedge clk);
        l1_trig_i = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!(hold_o | rclk_o | tk_in_o | fstrb_o | pulse_o | sample_o | done_o | busy_o | err_flag_o),
            "R1 outputs low in reset", hold_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(hold_o | busy_o | done_o | err_flag_o | rclk_o), "R1 outputs low after reset", busy_o, 0);

        // fault while idle is ignored
        fault_i = 1'b1;
        @(negedge clk);
        fault_i = 1'b0;
        @(negedge clk);
        chk(err_flag_o == 0, "R9 fault in idle ignored", err_flag_o, 0);

        // ---- full readout with a stray trigger mid-run
        push_strips(STRIPS);
        fire_trig();
        chk(hold_o && !rclk_o && !pulse_o, "R2 hold first, no rclk", hold_o, 1);
        chk(busy_o, "R8 busy after trigger", busy_o, 1);
        n = 0;
        repeat (SETUP) begin @(negedge clk); n++; end
        chk(rclk_o && tk_in_o, "R2 first rclk after setup", rclk_o, 1);
        @(negedge clk); n++;
        chk(rclk_o && tk_in_o, "R4 rclk high second cycle", rclk_o, 1);
        @(negedge clk); n++;
        chk(!rclk_o && tk_in_o, "R4 rclk low third cycle", rclk_o, 0);
        while (!fstrb_o && n < 7000) begin
            if (n == 100) l1_trig_i = 1'b1;
            if (n == 101) begin
                l1_trig_i = 1'b0;
                chk(busy_o, "R8 busy while reading", busy_o, 1);
            end
            @(negedge clk); n++;
        end
        chk(n == SETUP + STRIPS * STEP, "R6 R8 fstrb cycle after trigger", n, SETUP + STRIPS * STEP);
        chk(!hold_o && fstrb_o, "R6 hold dropped with fstrb", hold_o, 0);
        chk(exp_q.size() == 0, "R4 all strips sampled", exp_q.size(), 0);
        @(negedge clk);
        chk(done_o && !fstrb_o, "R6 done after fstrb", done_o, 1);
        @(negedge clk);
        chk(!busy_o && !done_o, "R6 idle after done", busy_o, 0);

        // ---- reject after strip 9
        push_strips(10);
        fire_trig();
        n = 0;
        while (n < 42) begin @(negedge clk); n++; end
        l2_rej_i = 1'b1;
        @(negedge clk);
        l2_rej_i = 1'b0;
        chk(fstrb_o && !hold_o && !rclk_o, "R7 abort on reject", fstrb_o, 1);
        @(negedge clk);
        chk(done_o, "R7 done after abort", done_o, 1);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && !busy_o, "R7 strips 0..9 only", exp_q.size(), 0);

        // ---- calibration mode
        cal_mode_i = 1'b1;
        fire_trig();
        cal_mode_i = 1'b0;
        chk(pulse_o && !hold_o, "R10 pulse before hold", pulse_o, 1);
        for (int k = 1; k < LEAD; k++) begin
            @(negedge clk);
            chk(!pulse_o && !hold_o, "R10 hold waits for lead", hold_o, 0);
        end
        @(negedge clk);
        chk(hold_o && !rclk_o, "R10 hold after lead", hold_o, 1);
        l2_rej_i = 1'b1;
        @(negedge clk);
        l2_rej_i = 1'b0;
        chk(fstrb_o && !hold_o, "R7 abort during setup", fstrb_o, 1);
        repeat (3) @(negedge clk);

        // ---- fault during reading
        push_strips(1);
        fire_trig();
        repeat (SETUP + 2) @(negedge clk);
        fault_i = 1'b1;
        @(negedge clk);
        fault_i = 1'b0;
        chk(err_flag_o, "R9 fault latched", err_flag_o, 1);
        l2_rej_i = 1'b1;
        @(negedge clk);
        l2_rej_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(err_flag_o && !busy_o, "R9 flag held after readout", err_flag_o, 1);
        fire_trig();
        chk(!err_flag_o, "R9 flag cleared by trigger", err_flag_o, 0);
        l2_rej_i = 1'b1;
        @(negedge clk);
        l2_rej_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !busy_o, "R7 no samples after early abort", exp_q.size(), 0);

        summary();
    end
endmodule